// File: doc/BRIEF.md
# Multimode 16-bit Down Counter/Timer

This block is a 16-bit down counter with a reload latch, a clock prescaler and a 3-bit mode field that picks one of eight behaviours. Four behaviours run freely and reload on underflow: event counting, pulse-width measurement, interval timing and pulse generation. Three are single-shot and stop after the first underflow: a retriggerable timer, an interval timer and a pulse generator. The last mode turns the counter off. One timer pin serves as a counting input, a gate, a retrigger input or a pulse output, depending on the mode.

Software reaches the block through a byte-wide register port with four addresses. Address 0 writes the low latch byte. A read of address 0 returns the low count byte and snapshots the high count byte. Address 1 writes the high latch byte, which starts the counter. A read of address 1 returns the snapshot. Address 2 holds the mode and address 3 returns the underflow flag. The flag drives the interrupt request. A parameter builds a reduced variant that supports only the four free-running behaviours.

Top module: `mm_timer16`

## Requirements
- R1: After reset the count, latch, mode and underflow flag are all zero. `irq` and `tmr_pin_oe` are low. The mode read at address 2 returns 0.
- R2: A write to address 0 changes only the low latch byte and leaves the count as it was. A write to address 1 loads the count with {written byte, low latch byte}, clears the flag, restarts the prescaler and starts the counter.
- R3: In the timing modes (3 to 7), the count falls by one every PRESC_DIV cycles. The first step comes PRESC_DIV clock edges after the loading write.
- R4: In the free-running modes (1, 2, 5, 7), a step taken at count 0 is an underflow. It reloads the count from the latch, so a period is PRESC_DIV*(latch+1) cycles.
- R5: In the single-shot modes (3, 4, 6), the first underflow stops the counter. The count then holds at 0 until the next write to address 1.
- R6: Each underflow sets the flag. `irq` equals the flag, and bit 0 of address 3 reads it.
- R7: Mode 1 (event count) steps once per falling edge of `tmr_pin_in`, seen through a two-stage synchronizer. The prescaler plays no part, and the count is steady while no edge arrives.
- R8: Mode 2 (pulse-width measurement) steps on prescaler ticks only while the synchronized pin is low. While the pin is high the count holds.
- R9: In mode 3 (retriggerable single-shot), a falling pin edge while the counter runs reloads the count from the latch. This postpones the underflow.
- R10: In modes 6 and 7 `tmr_pin_oe` is high. `tmr_pin_out` goes to 0 on a write to address 1 and toggles on every underflow. In all other modes `tmr_pin_oe` is low.
- R11: Reading address 0 returns count[7:0] and in the same cycle captures count[15:8]. A later read of address 1 returns that captured byte, even if the count has moved since.
- R12: With FULL_MODES=0, modes 3, 4 and 6 act as mode 0. The other modes behave as in the full variant.
- R13: In mode 0 the count never changes except by a write to address 1, and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 low, 1 high, 2 mode, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tmr_pin_in | input | 1 | Timer pin input value |
| tmr_pin_out | output | 1 | Timer pin output value in pulse modes |
| tmr_pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Underflow interrupt request |

## Verification
The loading write acts at edge E0. With latch L, prescaler steps land on E0+PRESC_DIV*j, and the underflow lands on E0+PRESC_DIV*(L+1). `irq` and `tmr_pin_out` change on that same edge, and the read data follows the count with no delay. The bench drives its inputs and samples the outputs on falling edges. It counts the rising edges since the load and compares against a model built on these formulas. Cases sit on both sides of a step, such as count 0 just before the underflow versus the reload just after it, and a coherent read straddles a step. Pin stimulus must pass two synchronizer stages and one edge register. So the pin-driven checks wait several cycles, or test a range where the prescaler phase is uncertain.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] RA_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] RA_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] RA_MODE = 2'd2;
  localparam logic [ADDR_W-1:0] RA_STAT = 2'd3;

  typedef enum logic [2:0] {
    MD_OFF      = 3'd0,
    MD_EVT      = 3'd1,
    MD_PWIDTH   = 3'd2,
    MD_RETRIG   = 3'd3,
    MD_OS_INT   = 3'd4,
    MD_FR_INT   = 3'd5,
    MD_OS_PULSE = 3'd6,
    MD_FR_PULSE = 3'd7
  } mode_t;

  function automatic logic is_oneshot(mode_t m);
    return (m == MD_RETRIG) || (m == MD_OS_INT) || (m == MD_OS_PULSE);
  endfunction

  function automatic logic is_pulse(mode_t m);
    return (m == MD_OS_PULSE) || (m == MD_FR_PULSE);
  endfunction

  function automatic logic reduced_ok(mode_t m);
    return (m == MD_EVT) || (m == MD_PWIDTH) || (m == MD_FR_INT) ||
           (m == MD_FR_PULSE) || (m == MD_OFF);
  endfunction

endpackage

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = ~restart;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] cnt_q;
      logic [PW-1:0] cnt_d;
      logic          at_end;

      assign at_end = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (restart)     cnt_d = '0;
        else if (at_end) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = at_end & ~restart;

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    end
  endgenerate

endmodule

// File: rtl/mmt_pin_sync.sv
module mmt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_lvl,
  output logic pin_fall
);

  localparam int CW = STAGES + 1;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CW-2:0], pin_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign pin_lvl  = chain_q[STAGES-1];
  assign pin_fall = chain_q[STAGES] & ~chain_q[STAGES-1];

  AST_FALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> !pin_fall); // R7

endmodule

// File: rtl/mmt_count_core.sv
module mmt_count_core
  import mmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  input  logic             pin_lvl,
  input  logic             pin_fall,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             uf
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             step_src;
  logic             step;
  logic             retrig;

  always_comb begin
    unique case (mode)
      MD_OFF:    step_src = 1'b0;
      MD_EVT:    step_src = pin_fall;
      MD_PWIDTH: step_src = tick & ~pin_lvl;
      default:   step_src = tick;
    endcase
  end

  assign step   = step_src & run_q;
  assign uf     = step & (cnt_q == '0);
  assign retrig = (mode == MD_RETRIG) & run_q & pin_fall;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (retrig) begin
      cnt_d = reload;
    end else if (uf) begin
      if (is_oneshot(mode)) run_d = 1'b0;
      else                  cnt_d = reload;
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)) && running); // R2
  AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !is_oneshot(mode) && !load && !retrig) |=> count == $past(reload)); // R4
  AST_OS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && is_oneshot(mode) && !load && !retrig) |=> (!running && count == '0)); // R5
  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig && !load) |=> count == $past(reload)); // R9
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFF && !load) |=> count == $past(count)); // R13
  AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_EVT && !pin_fall && !load) |=> count == $past(count)); // R7
  AST_PW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWIDTH && pin_lvl && !load) |=> count == $past(count)); // R8

endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
  import mmt_pkg::*;
#(
  parameter int PRESC_DIV   = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit FULL_MODES  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tmr_pin_in,
  output logic              tmr_pin_out,
  output logic              tmr_pin_oe,
  output logic              irq
);

  localparam int MODE_W = $bits(mode_t);
  localparam int PAD_W  = BYTE_W - MODE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // register decode
  logic wr_lo, wr_hi, wr_mode, rd_lo;
  assign wr_lo   = bus_sel &  bus_wr & (bus_addr == RA_LO);
  assign wr_hi   = bus_sel &  bus_wr & (bus_addr == RA_HI);
  assign wr_mode = bus_sel &  bus_wr & (bus_addr == RA_MODE);
  assign rd_lo   = bus_sel & ~bus_wr & (bus_addr == RA_LO);

  logic [BYTE_W-1:0] lat_lo_q, lat_lo_d;
  logic [BYTE_W-1:0] lat_hi_q, lat_hi_d;
  logic [BYTE_W-1:0] snap_q,   snap_d;
  mode_t             mode_q,   mode_d;
  logic              flag_q,   flag_d;
  logic              pout_q,   pout_d;

  mode_t             mode_eff;
  logic [CNT_W-1:0]  count;
  logic              running;
  logic              uf;
  logic              tick;
  logic              pin_lvl, pin_fall;

  generate
    if (FULL_MODES) begin : g_full
      assign mode_eff = mode_q;
    end else begin : g_reduced
      assign mode_eff = reduced_ok(mode_q) ? mode_q : MD_OFF;
    end
  endgenerate

  mmt_prescale #(.DIV(PRESC_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .restart (wr_hi),
    .tick    (tick)
  );

  mmt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pin_raw  (tmr_pin_in),
    .pin_lvl  (pin_lvl),
    .pin_fall (pin_fall)
  );

  mmt_count_core u_core (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .mode     (mode_eff),
    .load     (wr_hi),
    .load_val ({bus_wdata, lat_lo_q}),
    .reload   ({lat_hi_q, lat_lo_q}),
    .tick     (tick),
    .pin_lvl  (pin_lvl),
    .pin_fall (pin_fall),
    .count    (count),
    .running  (running),
    .uf       (uf)
  );

  always_comb begin
    lat_lo_d = wr_lo   ? bus_wdata : lat_lo_q;
    lat_hi_d = wr_hi   ? bus_wdata : lat_hi_q;
    mode_d   = wr_mode ? mode_t'(bus_wdata[MODE_W-1:0]) : mode_q;
    snap_d   = rd_lo   ? count[CNT_W-1:BYTE_W] : snap_q;

    flag_d = flag_q;
    if (wr_hi)   flag_d = 1'b0;
    else if (uf) flag_d = 1'b1;

    pout_d = pout_q;
    if (wr_hi)                        pout_d = 1'b0;
    else if (uf && is_pulse(mode_eff)) pout_d = ~pout_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
      snap_q   <= '0;
      mode_q   <= MD_OFF;
      flag_q   <= 1'b0;
      pout_q   <= 1'b0;
    end else begin
      lat_lo_q <= lat_lo_d;
      lat_hi_q <= lat_hi_d;
      snap_q   <= snap_d;
      mode_q   <= mode_d;
      flag_q   <= flag_d;
      pout_q   <= pout_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_LO:   bus_rdata = count[BYTE_W-1:0];
      RA_HI:   bus_rdata = snap_q;
      RA_MODE: bus_rdata = {{PAD_W{1'b0}}, mode_q};
      default: bus_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
    endcase
  end

  assign irq         = flag_q;
  assign tmr_pin_out = pout_q;
  assign tmr_pin_oe  = is_pulse(mode_eff);

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_hi |=> !irq); // R2
  AST_IRQ_ON_UF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (uf && !wr_hi) |=> irq); // R6
  AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (uf && is_pulse(mode_eff) && !wr_hi) |=> tmr_pin_out != $past(tmr_pin_out)); // R10
  AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_lo |=> snap_q == $past(count[CNT_W-1:BYTE_W])); // R11
  AST_REDUCED_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!FULL_MODES && is_oneshot(mode_q)) |-> !running || mode_eff == MD_OFF); // R12

endmodule

// File: tb/sim_mm_timer16.sv
module sim_mm_timer16;

  localparam int PRE = 4;
  localparam int NV  = 13;
  // {mode[7:0], latch[15:0], edges after load[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 16'd50,     8'd40},
    {8'd1, 16'd7,      8'd30},
    {8'd2, 16'd9,      8'd30},
    {8'd3, 16'd5,      8'd16},
    {8'd4, 16'd5,      8'd28},
    {8'd4, 16'd3,      8'd15},
    {8'd5, 16'd3,      8'd16},
    {8'd5, 16'h0123,   8'd20},
    {8'd5, 16'h0100,   8'd3},
    {8'd6, 16'd2,      8'd20},
    {8'd7, 16'd2,      8'd44},
    {8'd7, 16'd2,      8'd26},
    {8'd6, 16'd4,      8'd8}
  };

  logic       clk, rst_n, sel, wr, pin_in, done;
  logic [1:0] addr;
  logic [7:0] wdata, rd0, rd1;
  logic       po0, oe0, irq0, po1, oe1, irq1;
  int         checks, errors;

  mm_timer16 #(.PRESC_DIV(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd0), .tmr_pin_in(pin_in),
    .tmr_pin_out(po0), .tmr_pin_oe(oe0), .irq(irq0));

  mm_timer16 #(.PRESC_DIV(PRE), .FULL_MODES(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd1), .tmr_pin_in(pin_in),
    .tmr_pin_out(po1), .tmr_pin_oe(oe1), .irq(irq1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd8(input logic [1:0] a, output int v0, output int v1);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    v0 = int'(rd0); v1 = int'(rd1);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic rd16(output int v0, output int v1);
    logic [7:0] l0, l1;
    sel = 1'b1; wr = 1'b0; addr = 2'd0;
    #1;
    l0 = rd0; l1 = rd1;
    @(negedge clk);
    addr = 2'd1;
    #1;
    v0 = int'({rd0, l0}); v1 = int'({rd1, l1});
    sel = 1'b0;
  endtask

  task automatic start(input int m, input int lat);
    wreg(2'd2, 8'(m));
    wreg(2'd0, lat[7:0]);
    wreg(2'd1, lat[15:8]);
  endtask

  task automatic model(input int m, input int lat, input int n,
                       output int val, output int fl, output int po);
    int k, u;
    k = n / PRE;
    val = lat; fl = 0; po = 0;
    if (m == 5 || m == 7) begin
      u = k / (lat + 1);
      val = lat - (k % (lat + 1));
      fl = (u > 0) ? 1 : 0;
      po = (m == 7) ? (u % 2) : 0;
    end else if (m == 3 || m == 4 || m == 6) begin
      u = (k > lat) ? 1 : 0;
      val = (k > lat) ? 0 : lat - k;
      fl = u;
      po = (m == 6) ? u : 0;
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v0, v1, m, lat, n, ev, ef, ep, red;
    checks = 0; errors = 0;
    sel = 0; wr = 0; addr = 0; wdata = 0; pin_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq0), 0);
    chk("R1 pin_oe", int'(oe0), 0);
    rd16(v0, v1);
    chk("R1 count", v0, 0);
    rd8(2'd2, v0, v1);
    chk("R1 mode", v0, 0);
    rd8(2'd3, v0, v1);
    chk("R1 flag", v0, 0);

    // table walk: R3 R4 R5 R6 R10 R11 R12 R13
    for (int i = 0; i < NV; i++) begin
      m = int'(VEC[i][31:24]); lat = int'(VEC[i][23:8]); n = int'(VEC[i][7:0]);
      start(m, lat);
      repeat (n) @(negedge clk);
      model(m, lat, n, ev, ef, ep);
      red = (m == 3 || m == 4 || m == 6) ? 1 : 0;
      chk($sformatf("R6 irq vec%0d", i), int'(irq0), ef);
      chk($sformatf("R10 pin_out vec%0d", i), int'(po0), ep);
      chk($sformatf("R10 pin_oe vec%0d", i), int'(oe0), (m >= 6) ? 1 : 0);
      chk($sformatf("R12 irq vec%0d", i), int'(irq1), red ? 0 : ef);
      chk($sformatf("R12 pin_oe vec%0d", i), int'(oe1), (m == 7) ? 1 : 0);
      rd16(v0, v1);
      chk($sformatf("R3/R4/R5/R11/R13 count vec%0d", i), v0, ev);
      chk($sformatf("R12 count vec%0d", i), v1, red ? lat : ev);
    end

    // R7 event counting on falling pin edges
    start(1, 10);
    for (int p = 0; p < 3; p++) begin
      pin_in = 1'b0; repeat (3) @(negedge clk);
      pin_in = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd16(v0, v1);
    chk("R7 event count", v0, 7);
    chk("R7 event count reduced", v1, 7);

    // R8 pulse width: counts only while pin low
    start(2, 100);
    pin_in = 1'b0; repeat (40) @(negedge clk);
    pin_in = 1'b1; repeat (6) @(negedge clk);
    rd16(v0, v1);
    chk("R8 low window steps in 9..11", ((100 - v0) >= 9 && (100 - v0) <= 11) ? 1 : 0, 1);
    ev = v0;
    repeat (40) @(negedge clk);
    rd16(v0, v1);
    chk("R8 hold while high", v0, ev);

    // R9 retrigger postpones expiry
    start(3, 20);
    repeat (40) @(negedge clk);
    pin_in = 1'b0; repeat (3) @(negedge clk);
    pin_in = 1'b1; repeat (50) @(negedge clk);
    chk("R9 no expiry after retrigger", int'(irq0), 0);
    rd16(v0, v1);
    chk("R9 still counting", (v0 > 0) ? 1 : 0, 1);
    repeat (60) @(negedge clk);
    chk("R9 expiry later", int'(irq0), 1);
    rd16(v0, v1);
    chk("R5 hold at zero", v0, 0);
    rd8(2'd3, v0, v1);
    chk("R6 status bit", v0, 1);

    // R2 low write leaves count, high write loads and clears flag
    wreg(2'd2, 8'd0);
    wreg(2'd0, 8'h77);
    rd16(v0, v1);
    chk("R2 low write no load", v0, 0);
    chk("R2 flag kept", int'(irq0), 1);
    wreg(2'd1, 8'h12);
    chk("R2 flag cleared", int'(irq0), 0);
    rd16(v0, v1);
    chk("R2 high write loads", v0, 16'h1277);
    rd8(2'd2, v0, v1);
    chk("R13 mode readback", v0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule